// File: doc/BRIEF.md
# Token-Passing Cascadable FIFO Slice

This block is one slice of a deeper first-in first-out buffer. Identical slices are wired in a ring. They share one write strobe, one read strobe and the write data bus. Each slice owns a small local store, a write pointer and a read pointer, and holds no address information about its neighbours. Two tokens circulate around the ring. The write token names the slice that accepts the next word. The read token names the slice that presents the next word.

A slice gives up its write token in the cycle in which it stores into its last local location. It does so with a one-cycle pulse on its write hand-off output, and the next slice takes over on the following edge, starting at its location zero. Reads pass the read token the same way on a separate pulse. The slice marked as first-load holds both tokens out of reset. All others hold neither.

Each slice reports its own empty and full flags. Logic outside the slices combines them into the chain's flags: the chain is full when every slice is full and empty when every slice is empty. Read data is zero except in the cycle where a slice marks it valid, so the data outputs of all slices can simply be ORed together.

Top module: `fifo_ring_slice`

## Requirements
- R1: While rst_n is low and after it is released, both pointers are at location zero, empty is 1, full is 0, rd_valid is 0 and rd_data is 0. The slice holds both tokens if first_load is 1 and neither token if first_load is 0.
- R2: A word is stored at the next edge only when wr_en is 1, the slice holds the write token, and full is 0. In any other case wr_en has no effect on the stored contents or on the flags.
- R3: A read is taken at an edge only when rd_en is 1, the slice holds the read token, and empty is 0. In the cycle after that edge, rd_valid is 1 and rd_data carries the oldest unread word. In every other cycle rd_valid is 0 and rd_data is all zeros.
- R4: xo_wr is 1 for exactly the cycle in which an accepted write targets local location DEPTH-1. The write token leaves the slice at that edge, and the write pointer returns to zero.
- R5: xo_rd is 1 for exactly the cycle in which an accepted read targets local location DEPTH-1. The read token leaves the slice at that edge, and the read pointer returns to zero.
- R6: A 1 on xi_wr (xi_rd) during a cycle gives the slice the write (read) token from the next edge on, starting at local location zero.
- R7: empty is 1 exactly when the slice holds no unread word. full is 1 exactly when all DEPTH local locations hold unread words. The two flags are never 1 together.
- R8: A read and a write accepted at the same edge both take effect, and the occupancy stays unchanged.
- R9: N slices in a ring (each xo to the next xi, the last back to the first, one slice with first_load 1), with their flags ANDed, behave as one FIFO of N*DEPTH words. This holds in strict order across any number of token wraparounds, and a write to the full chain or a read from the empty chain is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| first_load | input | 1 | 1 marks the slice that holds both tokens after reset |
| wr_en | input | 1 | Shared write strobe |
| wr_data | input | DATA_W | Shared write data |
| rd_en | input | 1 | Shared read strobe |
| rd_data | output | DATA_W | Read word, all zeros unless rd_valid |
| rd_valid | output | 1 | rd_data carries a word from this slice |
| xi_wr | input | 1 | Write token arriving from the previous slice |
| xi_rd | input | 1 | Read token arriving from the previous slice |
| xo_wr | output | 1 | Write token pulse to the next slice |
| xo_rd | output | 1 | Read token pulse to the next slice |
| empty | output | 1 | No unread word in this slice |
| full | output | 1 | Every local location holds an unread word |

## Verification
A token held by the wrong slice shows up as a word that is lost or out of order. It appears at the combined read data within one pass of the ring, at most N*DEPTH reads later. A pointer or occupancy error shifts the position of the hand-off pulses, which are checked in the very cycle they occur, and the combined empty and full flags diverge from an arithmetic word count one edge after the fault. Long sweeps biased toward filling, toward draining and toward a balance drive the tokens around the ring many times. They press writes against the full chain and reads against the empty chain.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/ring_token_ptr.sv
module ring_token_ptr
   import fifo_ring_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PW = idx_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          first_load,
   input  logic          fire,
   input  logic          grant_in,
   output logic          hold,
   output logic [PW-1:0] ptr,
   output logic          pass_out
);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [PW-1:0] ptr_nxt;
   logic          at_last;

   assign at_last  = (ptr == LAST);
   assign pass_out = fire && at_last;

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_free
         assign ptr_nxt = ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = at_last ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold <= first_load;
         ptr  <= '0;
      end else begin
         if (fire) ptr <= ptr_nxt;
         hold <= (hold && !pass_out) || grant_in;
      end
   end
endmodule

// File: rtl/ring_store.sv
module ring_store
   import fifo_ring_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PW = idx_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [PW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= cells[raddr];
      else         rdata <= '0;
   end
endmodule

// File: rtl/ring_occupancy.sv
module ring_occupancy
   import fifo_ring_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CW = idx_bits(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic empty,
   output logic full
);
   logic [CW-1:0] level;

   always_ff @(posedge clk) begin
      if (!rst_n)           level <= '0;
      else if (inc && !dec) level <= level + 1'b1;
      else if (dec && !inc) level <= level - 1'b1;
   end

   assign empty = (level == '0);
   assign full  = (level == CW'(DEPTH));
endmodule

// File: rtl/fifo_ring_slice.sv
module fifo_ring_slice
   import fifo_ring_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PW = idx_bits(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              first_load,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic              xi_wr,
   input  logic              xi_rd,
   output logic              xo_wr,
   output logic              xo_rd,
   output logic              empty,
   output logic              full
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fifo_ring_slice: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("fifo_ring_slice: DATA_W must be at least 1");
      end
   endgenerate

   logic          wr_tok, rd_tok;
   logic          wr_fire, rd_fire;
   logic [PW-1:0] wptr, rptr;

   assign wr_fire = wr_en && wr_tok && !full;
   assign rd_fire = rd_en && rd_tok && !empty;

   ring_token_ptr #(.DEPTH(DEPTH)) u_wr_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .first_load (first_load),
      .fire       (wr_fire),
      .grant_in   (xi_wr),
      .hold       (wr_tok),
      .ptr        (wptr),
      .pass_out   (xo_wr)
   );

   ring_token_ptr #(.DEPTH(DEPTH)) u_rd_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .first_load (first_load),
      .fire       (rd_fire),
      .grant_in   (xi_rd),
      .hold       (rd_tok),
      .ptr        (rptr),
      .pass_out   (xo_rd)
   );

   ring_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_fire),
      .waddr (wptr),
      .wdata (wr_data),
      .re    (rd_fire),
      .raddr (rptr),
      .rdata (rd_data)
   );

   ring_occupancy #(.DEPTH(DEPTH)) u_level (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (wr_fire),
      .dec   (rd_fire),
      .empty (empty),
      .full  (full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rd_valid <= 1'b0;
      else        rd_valid <= rd_fire;
   end
endmodule

// File: rtl/fifo_ring_slice_chk.sv
module fifo_ring_slice_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              xi_wr,
   input logic              xi_rd,
   input logic              xo_wr,
   input logic              xo_rd,
   input logic              wr_tok,
   input logic              rd_tok,
   input logic              empty,
   input logic              full,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data
);
   p_xo_wr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xo_wr |-> (wr_en && wr_tok && !full));

   p_xo_wr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xo_wr |=> (!wr_tok || $past(xi_wr)));

   p_xo_rd_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xo_rd |-> (rd_en && rd_tok && !empty));

   p_xo_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      xo_rd |=> (!rd_tok || $past(xi_rd)));

   p_grant_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xi_wr |=> wr_tok);

   p_grant_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xi_rd |=> rd_tok);

   p_rd_valid_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en && rd_tok && !empty));

   p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   p_full_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(wr_en && wr_tok));

   p_empty_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty) |-> $past(rd_en && rd_tok));

   p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

bind fifo_ring_slice fifo_ring_slice_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .xi_wr    (xi_wr),
   .xi_rd    (xi_rd),
   .xo_wr    (xo_wr),
   .xo_rd    (xo_rd),
   .wr_tok   (wr_tok),
   .rd_tok   (rd_tok),
   .empty    (empty),
   .full     (full),
   .rd_valid (rd_valid),
   .rd_data  (rd_data)
);

// File: tb/fifo_ring_slice_bench.sv
`timescale 1ns/100ps
module fifo_ring_slice_bench;
   localparam int DW  = 8;
   localparam int D   = 4;
   localparam int NS  = 3;
   localparam int TOT = NS * D;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;

   logic [NS-1:0] xo_wr, xo_rd, full_v, empty_v, val_v;
   logic [DW-1:0] dat_v [NS];
   logic [DW-1:0] c_data;
   logic c_valid, c_full, c_empty;

   always #2.5 clk = ~clk;

   for (genvar i = 0; i < NS; i++) begin : g_slice
      fifo_ring_slice #(.DATA_W(DW), .DEPTH(D)) u_fifo_ring_slice (
         .clk        (clk),
         .rst_n      (rst_n),
         .first_load (i == 0),
         .wr_en      (wr_en),
         .wr_data    (wr_data),
         .rd_en      (rd_en),
         .rd_data    (dat_v[i]),
         .rd_valid   (val_v[i]),
         .xi_wr      (xo_wr[(i + NS - 1) % NS]),
         .xi_rd      (xo_rd[(i + NS - 1) % NS]),
         .xo_wr      (xo_wr[i]),
         .xo_rd      (xo_rd[i]),
         .empty      (empty_v[i]),
         .full       (full_v[i])
      );
   end

   always_comb begin
      c_data = '0;
      for (int i = 0; i < NS; i++) c_data = c_data | dat_v[i];
   end
   assign c_valid = |val_v;
   assign c_full  = &full_v;
   assign c_empty = &empty_v;

   int n_chk = 0, n_bad = 0;
   logic [DW-1:0] mdat [TOT];
   int wpos = 0, rpos = 0, cnt = 0;
   logic exp_valid = 1'b0;
   logic [DW-1:0] exp_data = '0;
   logic [DW-1:0] seq = 8'h01;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk("R3 rd_valid", 32'(c_valid), 32'(exp_valid));
      chk("R3 rd_data", 32'(c_data), 32'(exp_valid ? exp_data : '0));
      chk("R9 chain empty", 32'(c_empty), 32'(cnt == 0));
      chk("R9 chain full", 32'(c_full), 32'(cnt == TOT));
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic we, input logic re);
      logic wacc, racc;
      logic [NS-1:0] exp_xw, exp_xr;
      wr_en = we; rd_en = re; wr_data = seq;
      #1;
      wacc = we && (cnt < TOT);
      racc = re && (cnt > 0);
      exp_xw = '0; exp_xr = '0;
      for (int i = 0; i < NS; i++) begin
         if (wacc && wpos == i * D + D - 1) exp_xw[i] = 1'b1;
         if (racc && rpos == i * D + D - 1) exp_xr[i] = 1'b1;
      end
      chk("R4 xo_wr", 32'(xo_wr), 32'(exp_xw));
      chk("R5 xo_rd", 32'(xo_rd), 32'(exp_xr));
      @(posedge clk);
      exp_valid = racc;
      if (racc) begin
         exp_data = mdat[rpos];
         rpos = (rpos + 1) % TOT;
      end
      if (wacc) begin
         mdat[wpos] = seq;
         wpos = (wpos + 1) % TOT;
      end
      if (we) seq = seq + 8'd1;
      cnt = cnt + int'(wacc) - int'(racc);
      @(negedge clk);
      check_outputs();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wpos = 0; rpos = 0; cnt = 0; exp_valid = 1'b0;
      chk("R1 slice empty", 32'(empty_v), 32'({NS{1'b1}}));
      chk("R1 slice full", 32'(full_v), 32'(0));
      check_outputs();
   endtask

   task automatic sweep(input int cycles, input int wr_thr, input int rd_thr);
      for (int k = 0; k < cycles; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(int'(lfsr[3:0]) < wr_thr, int'(lfsr[7:4]) < rd_thr);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R3/R9: reads on the empty chain are ignored
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      // R2 R4 R6: fill all slices, tokens move at local locations 3
      for (int k = 0; k < TOT; k++) step(1'b1, 1'b0);
      // R2: writes on a full chain are ignored
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      // R5 R6 R9: drain in order, then one extra read
      for (int k = 0; k < TOT + 1; k++) step(1'b0, 1'b1);
      // R8: simultaneous read and write in a steady stream
      step(1'b1, 1'b0);
      for (int k = 0; k < 3 * TOT; k++) step(1'b1, 1'b1);
      // R1: a second reset returns the tokens to slice 0
      do_reset();
      for (int k = 0; k < 5; k++) step(1'b1, 1'b0);
      for (int k = 0; k < 5; k++) step(1'b0, 1'b1);
      // R9: mixed sweeps, write-heavy, read-heavy, balanced
      sweep(400, 13, 5);
      sweep(400, 5, 13);
      sweep(800, 8, 8);
      sweep(400, 15, 15);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule